// File: doc/BRIEF.md
# Data-Triggered Tile Instruction Sequencer

This block is the small in-order controller inside one tile of a compute array. It steps through a short program held in an instruction memory outside the block, reading one 32-bit instruction word per cycle through a combinational fetch port. It works on sixteen 32-bit general registers. It talks to the tile's network through sixteen receive heads and sixteen send heads, one of each per (side, color) pair. Each receive head gives a ready flag and a data word. Each send head gives a busy flag. The block replies with one-hot consume and load strobes.

Control flow follows the data. The trigger instructions branch when chosen receive heads hold words. The communication instructions hold the program counter until the head flags let them finish, so data arrival sets the pace of the program. Register arithmetic covers multiply-accumulate, add with a register or an immediate operand, and compare-with-immediate branches. A done instruction halts the sequencer for good until reset. Label targets are absolute instruction addresses, already resolved when the program was loaded.

Top module: `tile_seq`

## Requirements
- R1: After reset the fetch address is 0, `done` is low, all registers read as 0, and no consume or load strobe is active while the instruction at address 0 waits.
- R2: The two-input trigger (opcode 7) jumps to its target when the receive heads on channel A and channel B are both ready. Otherwise it goes to the next address. It consumes nothing.
- R3: The one-input trigger (opcode 6) jumps to its target when channel A is ready. Otherwise it goes to the next address. It consumes nothing.
- R4: The blocking wait (opcode 2) holds the fetch address while channel A is not ready. In the cycle it is ready, it pulses that channel's consume strobe, writes the word to register rd and advances.
- R5: The blocking send (opcode 3) holds while send head A is busy. Otherwise it loads register ra into send head A and advances. A load strobe never rises on a busy head.
- R6: Receive-and-forward (opcode 4) holds while channel A is not ready. Once channel A is ready, it consumes the word into rd. In that same cycle, if send head B is free, it also loads the word into B and advances.
- R7: When receive-and-forward consumes a word while send head B is busy, it keeps the word in a pending latch and holds. While the word is pending it consumes nothing more. It loads the kept word once B is free, then advances.
- R8: Multiply-accumulate (opcode 8) sets rd to rd + ra*rb, modulo 2^32.
- R9: Add (opcode 9) sets rd to ra + rb when bit 0 is 0, and to ra + the zero-extended immediate field when bit 0 is 1, modulo 2^32.
- R10: The unconditional jump (opcode 10) goes to its target. The equal branch (11) and the not-equal branch (12) compare ra with the zero-extended 8-bit immediate and go to the target on a match of their condition. Otherwise they go to the next address.
- R11: Idle (opcode 0) only advances, so a straight-line program of N single-cycle instructions plus a final done raises `done` after N+1 clocks.
- R12: Trigger-send (opcode 5) swaps rd with a word from channel A and loads the old rd into send head B, but only when A is ready and B is free. It always advances.
- R13: Done (opcode 1) raises `done`. From then on the fetch address, the registers and all strobes stay still until reset.
- R14: The encoding is: opcode [31:27], rd [26:23], ra [22:19], rb and channel A share [18:15], channel B [14:11], immediate [15:8], target [7:0], immediate select [0]. A channel number is side*4 + color, and that number is the bit index in the ready, busy, consume and load vectors and the word index in `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 6 | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| rx_ready | input | 16 | Receive head holds a word, one bit per channel |
| rx_data | input | 512 | Receive head words, 32 bits per channel |
| rx_take | output | 16 | One-hot consume strobe for a receive head |
| tx_busy | input | 16 | Send head is occupied, one bit per channel |
| tx_load | output | 16 | One-hot load strobe for a send head |
| tx_data | output | 32 | Word loaded by `tx_load` |
| done | output | 1 | Sequencer has halted |

## Verification
The consume and load strobes are combinational. They appear in the same cycle the instruction sits at `imem_addr` and its flags allow progress. A register write or a new fetch address shows one clock later, and `done` shows one clock after the done instruction is fetched. The bench changes head flags at the falling edge and checks the strobes a moment later, before the next rising edge. It checks the fetch address after each rising edge, and for straight-line programs it counts the exact number of clocks until `done`. Register results are sent out and compared against a log of load strobes captured at the rising edges.

// File: rtl/tile_seq_pkg.sv
package tile_seq_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned CH_AW  = 4;
  localparam int unsigned FLD_W  = 8;

  // field positions inside an instruction word
  localparam int unsigned OP_LSB  = XLEN - OP_W;
  localparam int unsigned RD_LSB  = OP_LSB - REG_AW;
  localparam int unsigned RA_LSB  = RD_LSB - REG_AW;
  localparam int unsigned RB_LSB  = RA_LSB - REG_AW;
  localparam int unsigned CHB_LSB = RB_LSB - CH_AW;
  localparam int unsigned IMM_LSB = FLD_W;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 5'd0,
    OP_DONE  = 5'd1,
    OP_WAIT  = 5'd2,
    OP_SEND  = 5'd3,
    OP_RSEND = 5'd4,
    OP_TSEND = 5'd5,
    OP_TRIG1 = 5'd6,
    OP_TRIG2 = 5'd7,
    OP_MAC   = 5'd8,
    OP_ADD   = 5'd9,
    OP_JMP   = 5'd10,
    OP_JEQ   = 5'd11,
    OP_JNE   = 5'd12
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [CH_AW-1:0]  cha;
    logic [CH_AW-1:0]  chb;
    logic [FLD_W-1:0]  imm;
    logic [FLD_W-1:0]  tgt;
    logic              isel;
  } instr_t;

  function automatic word_t mac_wrap(word_t acc, word_t a, word_t b);
    word_t prod;
    prod = a * b;
    return acc + prod;
  endfunction

  function automatic word_t add_pick(word_t a, word_t r, logic [FLD_W-1:0] imm, logic use_imm);
    word_t rhs;
    rhs = use_imm ? word_t'(imm) : r;
    return a + rhs;
  endfunction

  function automatic logic branch_hit(op_e op, word_t v, logic [FLD_W-1:0] imm);
    logic same;
    same = (v == word_t'(imm));
    return (op == OP_JEQ) ? same : !same;
  endfunction
endpackage

// File: rtl/tile_seq_decode.sv
module tile_seq_decode
  import tile_seq_pkg::*;
(
  input  logic [XLEN-1:0] word_i,
  output instr_t          ins_o
);
  always_comb begin
    ins_o.op   = op_e'(word_i[OP_LSB +: OP_W]);
    ins_o.rd   = word_i[RD_LSB +: REG_AW];
    ins_o.ra   = word_i[RA_LSB +: REG_AW];
    ins_o.rb   = word_i[RB_LSB +: REG_AW];
    ins_o.cha  = word_i[RB_LSB +: CH_AW];
    ins_o.chb  = word_i[CHB_LSB +: CH_AW];
    ins_o.imm  = word_i[IMM_LSB +: FLD_W];
    ins_o.tgt  = word_i[0 +: FLD_W];
    ins_o.isel = word_i[0];
  end
endmodule

// File: rtl/tile_seq_regfile.sv
module tile_seq_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 32,
  parameter int unsigned NRD  = 3,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         regs[g] <= '0;
      else if (we && waddr == AW'(g))     regs[g] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = regs[raddr[r]];
  end
endmodule

// File: rtl/tile_seq_chan.sv
module tile_seq_chan #(
  parameter int unsigned NCH = 16,
  parameter int unsigned W   = 32,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   rx_ready,
  input  logic [NCH*W-1:0] rx_data,
  input  logic [NCH-1:0]   tx_busy,
  input  logic [CW-1:0]    sel_a,
  input  logic [CW-1:0]    sel_b,
  input  logic             take_en,
  input  logic             load_en,
  input  logic [CW-1:0]    load_ch,
  output logic             rdy_a,
  output logic             rdy_b,
  output logic             busy_a,
  output logic             busy_b,
  output logic [W-1:0]     word_a,
  output logic [NCH-1:0]   rx_take,
  output logic [NCH-1:0]   tx_load
);
  assign rdy_a  = rx_ready[sel_a];
  assign rdy_b  = rx_ready[sel_b];
  assign busy_a = tx_busy[sel_a];
  assign busy_b = tx_busy[sel_b];
  assign word_a = rx_data[sel_a*W +: W];

  for (genvar g = 0; g < NCH; g++) begin : g_strobe
    assign rx_take[g] = take_en && (sel_a == CW'(g));
    assign tx_load[g] = load_en && (load_ch == CW'(g));
  end

  // at most one head of each kind is touched per cycle
  assert_single_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_take));
  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_load));
endmodule

// File: rtl/tile_seq.sv
module tile_seq
  import tile_seq_pkg::*;
#(
  parameter int unsigned NREG       = 16,
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned NSIDE      = 4,
  parameter int unsigned NCOLOR     = 4,
  localparam int unsigned IMEM_AW   = $clog2(IMEM_DEPTH),
  localparam int unsigned NCH       = NSIDE * NCOLOR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [IMEM_AW-1:0]    imem_addr,
  input  logic [XLEN-1:0]       imem_rdata,
  input  logic [NCH-1:0]        rx_ready,
  input  logic [NCH*XLEN-1:0]   rx_data,
  output logic [NCH-1:0]        rx_take,
  input  logic [NCH-1:0]        tx_busy,
  output logic [NCH-1:0]        tx_load,
  output logic [XLEN-1:0]       tx_data,
  output logic                  done
);
  localparam int unsigned NRD = 3;

  instr_t             ins;
  logic [IMEM_AW-1:0] pc, pc_nx, pc_tgt;
  logic               halted, halt_set;
  logic               pend_v, pend_set, pend_clr;
  word_t              pend_w;

  logic               we;
  word_t              wdata;
  logic [NRD-1:0][REG_AW-1:0] raddr;
  logic [NRD-1:0][XLEN-1:0]   rdata;
  word_t              v_rd, v_ra, v_rb;

  logic               take_en, load_en;
  logic [CH_AW-1:0]   load_ch;
  word_t              load_w;
  logic               rdy_a, rdy_b, busy_a, busy_b;
  word_t              word_a;

  // named events for the checks below
  logic               ev_stall, ev_wait_block, ev_pending;

  tile_seq_decode u_dec (.word_i(imem_rdata), .ins_o(ins));

  assign raddr = {ins.rb, ins.ra, ins.rd};
  assign v_rd  = rdata[0];
  assign v_ra  = rdata[1];
  assign v_rb  = rdata[2];

  tile_seq_regfile #(.NREG(NREG), .W(XLEN), .NRD(NRD)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(ins.rd), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  tile_seq_chan #(.NCH(NCH), .W(XLEN)) u_chan (
    .clk(clk), .rst_n(rst_n),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_busy(tx_busy),
    .sel_a(ins.cha), .sel_b(ins.chb),
    .take_en(take_en), .load_en(load_en), .load_ch(load_ch),
    .rdy_a(rdy_a), .rdy_b(rdy_b), .busy_a(busy_a), .busy_b(busy_b),
    .word_a(word_a), .rx_take(rx_take), .tx_load(tx_load)
  );

  assign pc_tgt = IMEM_AW'(ins.tgt);

  always_comb begin
    pc_nx    = pc + 1'b1;
    we       = 1'b0;
    wdata    = '0;
    take_en  = 1'b0;
    load_en  = 1'b0;
    load_ch  = ins.chb;
    load_w   = '0;
    pend_set = 1'b0;
    pend_clr = 1'b0;
    halt_set = 1'b0;
    if (halted) begin
      pc_nx = pc;
    end else begin
      case (ins.op)
        OP_DONE: begin
          pc_nx    = pc;
          halt_set = 1'b1;
        end
        OP_WAIT: begin
          if (rdy_a) begin
            take_en = 1'b1;
            we      = 1'b1;
            wdata   = word_a;
          end else begin
            pc_nx = pc;
          end
        end
        OP_SEND: begin
          load_ch = ins.cha;
          if (!busy_a) begin
            load_en = 1'b1;
            load_w  = v_ra;
          end else begin
            pc_nx = pc;
          end
        end
        OP_RSEND: begin
          if (pend_v) begin
            if (!busy_b) begin
              load_en  = 1'b1;
              load_w   = pend_w;
              pend_clr = 1'b1;
            end else begin
              pc_nx = pc;
            end
          end else if (rdy_a) begin
            take_en = 1'b1;
            we      = 1'b1;
            wdata   = word_a;
            if (!busy_b) begin
              load_en = 1'b1;
              load_w  = word_a;
            end else begin
              pend_set = 1'b1;
              pc_nx    = pc;
            end
          end else begin
            pc_nx = pc;
          end
        end
        OP_TSEND: begin
          if (rdy_a && !busy_b) begin
            take_en = 1'b1;
            we      = 1'b1;
            wdata   = word_a;
            load_en = 1'b1;
            load_w  = v_rd;
          end
        end
        OP_TRIG1: if (rdy_a)          pc_nx = pc_tgt;
        OP_TRIG2: if (rdy_a && rdy_b) pc_nx = pc_tgt;
        OP_MAC: begin
          we    = 1'b1;
          wdata = mac_wrap(v_rd, v_ra, v_rb);
        end
        OP_ADD: begin
          we    = 1'b1;
          wdata = add_pick(v_ra, v_rb, ins.imm, ins.isel);
        end
        OP_JMP: pc_nx = pc_tgt;
        OP_JEQ, OP_JNE: if (branch_hit(ins.op, v_ra, ins.imm)) pc_nx = pc_tgt;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      halted <= 1'b0;
      pend_v <= 1'b0;
      pend_w <= '0;
    end else begin
      pc     <= pc_nx;
      halted <= halted | halt_set;
      if (pend_set) begin
        pend_v <= 1'b1;
        pend_w <= word_a;
      end else if (pend_clr) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign imem_addr = pc;
  assign done      = halted;
  assign tx_data   = load_en ? load_w : '0;

  assign ev_stall      = (pc_nx == pc);
  assign ev_wait_block = !halted && (ins.op == OP_WAIT) && !rdy_a;
  assign ev_pending    = pend_v;

  assert_take_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take & ~rx_ready) == '0);
  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait_block |=> $stable(imem_addr));
  assert_load_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load & tx_busy) == '0);
  assert_pend_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pending |-> rx_take == '0);
  assert_idle_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && ins.op == OP_IDLE) |=> imem_addr == $past(imem_addr) + 1'b1);
  assert_tsend_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && ins.op == OP_TSEND) |=> imem_addr == $past(imem_addr) + 1'b1);
  assert_done_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(imem_addr) && rx_take == '0 && tx_load == '0);
  assert_halt_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ev_stall);
endmodule

// File: tb/test_tile_seq.sv
module test_tile_seq;
  localparam int NCH = 16;

  // opcode values from R14 and the requirement list
  localparam logic [4:0] C_IDLE = 5'd0, C_DONE = 5'd1, C_WAIT = 5'd2, C_SEND = 5'd3,
    C_RSEND = 5'd4, C_TSEND = 5'd5, C_TRIG1 = 5'd6, C_TRIG2 = 5'd7, C_MAC = 5'd8,
    C_ADD = 5'd9, C_JMP = 5'd10, C_JEQ = 5'd11, C_JNE = 5'd12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [5:0]        imem_addr;
  logic [31:0]       imem_rdata;
  logic [NCH-1:0]    rx_ready;
  logic [NCH*32-1:0] rx_data = '0;
  logic [NCH-1:0]    rx_take;
  logic [NCH-1:0]    tx_busy = '0;
  logic [NCH-1:0]    tx_load;
  logic [31:0]       tx_data;
  logic              done;

  logic [31:0]       imem [64];
  logic [NCH-1:0]    rx_set = '0;
  logic [NCH-1:0]    rx_pre = '0;
  logic              log_clr = 1'b1;
  int                log_n, take_n;
  logic [3:0]        log_ch [16];
  logic [31:0]       log_d  [16];
  int                n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign imem_rdata = imem[imem_addr];

  tile_seq i_tile_seq (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_take(rx_take),
    .tx_busy(tx_busy), .tx_load(tx_load), .tx_data(tx_data), .done(done)
  );

  function automatic logic [3:0] hot_idx(logic [NCH-1:0] v);
    logic [3:0] r = '0;
    for (int i = 0; i < NCH; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  // head model and load log
  always @(posedge clk) begin
    if (!rst_n) rx_ready <= rx_pre;
    else        rx_ready <= (rx_ready & ~rx_take) | rx_set;
    if (log_clr) begin
      log_n  <= 0;
      take_n <= 0;
    end else begin
      take_n <= take_n + $countones(rx_take);
      if (|tx_load && log_n < 16) begin
        log_ch[log_n] <= hot_idx(tx_load);
        log_d[log_n]  <= tx_data;
        log_n         <= log_n + 1;
      end
    end
  end

  function automatic logic [31:0] e_ch(logic [4:0] op, logic [3:0] rd, logic [3:0] ra,
                                       logic [3:0] cha, logic [3:0] chb, logic [7:0] tgt);
    return {op, rd, ra, cha, chb, 3'b0, tgt};
  endfunction
  function automatic logic [31:0] e_rr(logic [4:0] op, logic [3:0] rd, logic [3:0] ra, logic [3:0] rb);
    return {op, rd, ra, rb, 15'b0};
  endfunction
  function automatic logic [31:0] e_addi(logic [3:0] rd, logic [3:0] ra, logic [7:0] imm);
    return {C_ADD, rd, ra, 3'b0, imm, 7'b0, 1'b1};
  endfunction
  function automatic logic [31:0] e_br(logic [4:0] op, logic [3:0] ra, logic [7:0] imm, logic [7:0] tgt);
    return {op, 4'b0, ra, 3'b0, imm, tgt};
  endfunction

  function automatic logic [31:0] exp_mac(logic [31:0] acc, logic [31:0] a, logic [31:0] b);
    logic [63:0] p;
    p = {32'b0, a} * {32'b0, b};
    return 32'((64'(acc) + p) & 64'hFFFF_FFFF);
  endfunction
  function automatic logic [31:0] exp_add(logic [31:0] a, logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) imem[i] = {C_DONE, 27'b0};
  endtask

  task automatic restart(input logic [NCH-1:0] pre);
    rst_n   = 1'b0;
    log_clr = 1'b1;
    rx_set  = '0;
    rx_pre  = pre;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n   = 1'b1;
    log_clr = 1'b0;
    #1;
  endtask

  task automatic run_to_done(output int n);
    n = 0;
    while (!done && n < 300) begin
      cyc();
      n++;
    end
  endtask

  task automatic put_word(input int ch, input logic [31:0] d);
    rx_data[ch*32 +: 32] = d;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [31:0] a, b, c, w;
    logic [7:0]  k;
    void'($urandom(1234));

    // ---- reset state and blocked send (R1, R5)
    clear_prog();
    imem[0] = e_ch(C_SEND, 0, 7, 1, 0, 0);
    tx_busy = 16'h0002;
    restart('0);
    chk("R1 fetch address after reset", 32'(imem_addr), 0);
    chk("R1 done low after reset", 32'(done), 0);
    chk("R1 no consume after reset", 32'(rx_take), 0);
    chk("R5 no load on busy head", 32'(tx_load), 0);
    cyc();
    chk("R5 send holds while busy", 32'(imem_addr), 0);
    tx_busy = '0;
    #1;
    chk("R5 load strobe when free", 32'(tx_load), 32'h0002);
    chk("R1 register reads zero", tx_data, 0);
    cyc();
    chk("R5 send advances", 32'(imem_addr), 1);

    // ---- arithmetic, idle and timing (R8, R9, R11, R13)
    for (int r = 0; r < 7; r++) begin
      a = (r == 0) ? 32'hFFFF_FFFF : $urandom;
      b = (r == 0) ? 32'hFFFF_FFFF : $urandom;
      c = (r == 0) ? 32'hFFFF_FFFF : $urandom;
      k = (r == 0) ? 8'hFF : 8'($urandom);
      clear_prog();
      imem[0] = e_ch(C_WAIT, 1, 0, 0, 0, 0);
      imem[1] = e_ch(C_WAIT, 2, 0, 1, 0, 0);
      imem[2] = e_ch(C_WAIT, 3, 0, 2, 0, 0);
      imem[3] = e_rr(C_MAC, 3, 1, 2);
      imem[4] = e_rr(C_ADD, 4, 1, 2);
      imem[5] = e_addi(5, 1, k);
      imem[6] = {C_IDLE, 27'b0};
      imem[7] = e_ch(C_SEND, 0, 3, 4, 0, 0);
      imem[8] = e_ch(C_SEND, 0, 4, 5, 0, 0);
      imem[9] = e_ch(C_SEND, 0, 5, 6, 0, 0);
      put_word(0, a); put_word(1, b); put_word(2, c);
      restart(16'h0007);
      run_to_done(n);
      chk("R11 clocks to done", 32'(n), 11);
      chk("R4 words consumed", 32'(take_n), 3);
      chk("R8 mac result", log_d[0], exp_mac(c, a, b));
      chk("R9 add register operand", log_d[1], exp_add(a, b));
      chk("R9 add immediate operand", log_d[2], exp_add(a, {24'b0, k}));
      chk("R14 mac result channel", 32'(log_ch[0]), 4);
      if (r == 0) begin
        repeat (3) cyc();
        chk("R13 done stays high", 32'(done), 1);
        chk("R13 no loads after done", 32'(log_n), 3);
        chk("R13 fetch address frozen", 32'(imem_addr), 10);
      end
    end

    // ---- triggers, all input patterns (R2, R3)
    for (int m = 0; m < 8; m++) begin
      logic [NCH-1:0] pre;
      logic [31:0] ex;
      clear_prog();
      imem[0]  = e_ch(C_TRIG2, 0, 0, 3, 6, 4);
      imem[1]  = e_ch(C_TRIG1, 0, 0, 9, 0, 7);
      imem[2]  = e_addi(1, 0, 11);
      imem[3]  = e_ch(C_JMP, 0, 0, 0, 0, 10);
      imem[4]  = e_addi(1, 0, 22);
      imem[5]  = e_ch(C_JMP, 0, 0, 0, 0, 10);
      imem[7]  = e_addi(1, 0, 33);
      imem[8]  = e_ch(C_JMP, 0, 0, 0, 0, 10);
      imem[10] = e_ch(C_SEND, 0, 1, 15, 0, 0);
      pre = '0;
      pre[3] = m[0]; pre[6] = m[1]; pre[9] = m[2];
      ex = (m[0] && m[1]) ? 22 : (m[2] ? 33 : 11);
      restart(pre);
      run_to_done(n);
      chk("R2 R3 trigger path taken", log_d[0], ex);
      chk("R3 triggers consume nothing", 32'(take_n), 0);
    end

    // ---- blocking wait then send, cycle by cycle (R4, R5)
    clear_prog();
    imem[0] = e_ch(C_WAIT, 2, 0, 7, 0, 0);
    imem[1] = e_ch(C_SEND, 0, 2, 8, 0, 0);
    tx_busy = 16'h0100;
    restart('0);
    for (int i = 0; i < 3; i++) begin
      chk("R4 wait holds", 32'(imem_addr), 0);
      chk("R4 no consume while empty", 32'(rx_take), 0);
      cyc();
    end
    w = $urandom;
    put_word(7, w);
    rx_set = 16'h0080;
    cyc();
    rx_set = '0;
    #1;
    chk("R4 consume strobe on ready", 32'(rx_take), 32'h0080);
    cyc();
    chk("R4 wait advances", 32'(imem_addr), 1);
    chk("R5 no load while busy", 32'(tx_load), 0);
    cyc();
    chk("R5 send still held", 32'(imem_addr), 1);
    tx_busy = '0;
    #1;
    chk("R5 load strobe channel 8", 32'(tx_load), 32'h0100);
    chk("R4 waited word stored", tx_data, w);
    cyc();
    chk("R5 advance after load", 32'(imem_addr), 2);

    // ---- receive-and-forward with pending latch (R6, R7)
    clear_prog();
    imem[0] = e_ch(C_RSEND, 4, 0, 1, 10, 0);
    imem[1] = e_ch(C_SEND, 0, 4, 11, 0, 0);
    imem[2] = e_ch(C_RSEND, 5, 0, 1, 10, 0);
    imem[3] = e_ch(C_SEND, 0, 5, 11, 0, 0);
    imem[4] = {C_DONE, 27'b0};
    tx_busy = '0;
    restart('0);
    for (int i = 0; i < 3; i++) begin
      chk("R6 holds while source empty", 32'(imem_addr), 0);
      chk("R6 no load while source empty", 32'(tx_load), 0);
      cyc();
    end
    a = $urandom;
    put_word(1, a);
    rx_set = 16'h0002;
    cyc();
    rx_set = '0;
    #1;
    chk("R6 consume on ready", 32'(rx_take), 32'h0002);
    chk("R6 forward strobe", 32'(tx_load), 32'h0400);
    chk("R6 forward word", tx_data, a);
    cyc();
    chk("R6 advanced", 32'(imem_addr), 1);
    chk("R6 register holds word", tx_data, a);
    cyc();
    tx_busy = 16'h0400;
    b = $urandom;
    put_word(1, b);
    rx_set = 16'h0002;
    cyc();
    rx_set = '0;
    #1;
    chk("R7 consume while dest busy", 32'(rx_take), 32'h0002);
    chk("R7 no load while busy", 32'(tx_load), 0);
    cyc();
    chk("R7 holds with pending word", 32'(imem_addr), 2);
    c = b ^ 32'h5A5A_0001;
    put_word(1, c);
    rx_set = 16'h0002;
    cyc();
    rx_set = '0;
    #1;
    chk("R7 no second consume", 32'(rx_take), 0);
    tx_busy = '0;
    #1;
    chk("R7 pending load strobe", 32'(tx_load), 32'h0400);
    chk("R7 pending word sent", tx_data, b);
    cyc();
    chk("R7 advanced after pending send", 32'(imem_addr), 3);
    chk("R7 register got first word", tx_data, b);
    run_to_done(n);
    chk("R7 exactly two words consumed", 32'(take_n), 2);

    // ---- compare branches (R10)
    for (int r = 0; r < 8; r++) begin
      int s;
      logic [31:0] v;
      logic eq;
      k = 8'($urandom);
      s = $urandom % 3;
      v = (s == 0) ? {24'b0, k} : (s == 1) ? {24'b0, k ^ 8'(1 << ($urandom % 8))} : {24'b0, k} | 32'h0010_0000;
      eq = (v == {24'b0, k});
      clear_prog();
      imem[0]  = e_ch(C_WAIT, 1, 0, 0, 0, 0);
      imem[1]  = e_br(C_JEQ, 1, k, 4);
      imem[2]  = e_addi(2, 0, 1);
      imem[3]  = e_ch(C_JMP, 0, 0, 0, 0, 5);
      imem[4]  = e_addi(2, 0, 2);
      imem[5]  = e_br(C_JNE, 1, k, 8);
      imem[6]  = e_addi(3, 0, 3);
      imem[7]  = e_ch(C_JMP, 0, 0, 0, 0, 9);
      imem[8]  = e_addi(3, 0, 4);
      imem[9]  = e_ch(C_SEND, 0, 2, 2, 0, 0);
      imem[10] = e_ch(C_SEND, 0, 3, 3, 0, 0);
      put_word(0, v);
      restart(16'h0001);
      run_to_done(n);
      chk("R10 equal branch", log_d[0], eq ? 2 : 1);
      chk("R10 not-equal branch", log_d[1], eq ? 3 : 4);
    end

    // ---- trigger-send exchange (R12)
    for (int cs = 0; cs < 3; cs++) begin
      w = $urandom;
      clear_prog();
      imem[0] = e_addi(6, 0, 77);
      imem[1] = e_ch(C_TSEND, 6, 0, 4, 9, 0);
      imem[2] = e_ch(C_SEND, 0, 6, 13, 0, 0);
      put_word(4, w);
      tx_busy = (cs == 2) ? 16'h0200 : '0;
      restart((cs != 1) ? 16'h0010 : '0);
      run_to_done(n);
      chk("R12 always advances", 32'(n), 4);
      if (cs == 0) begin
        chk("R12 two loads", 32'(log_n), 2);
        chk("R12 old value sent", log_d[0], 77);
        chk("R12 old value channel", 32'(log_ch[0]), 9);
        chk("R12 register took word", log_d[1], w);
        chk("R12 one consume", 32'(take_n), 1);
      end else begin
        chk("R12 no exchange load", 32'(log_n), 1);
        chk("R12 register unchanged", log_d[0], 77);
        chk("R12 nothing consumed", 32'(take_n), 0);
      end
    end
    tx_busy = '0;

    summary();
    $finish;
  end
endmodule